// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave end of a two-wire serial memory holding sixteen bytes in a register file. It oversamples the clock and data lines of the bus with the system clock, finds START and STOP conditions, and checks an incoming control byte against a fixed device code. A write transaction loads a word address into an internal pointer and then accepts one data byte. The STOP that closes a write starts a timed internal write cycle. A read transaction streams bytes out, starting at the pointer.

The data line is open-drain. The block only ever pulls it low, through an output enable, and the bench or the pad models the wired-AND. The slave never stretches the clock, so the master sets the pace of every transfer. While a byte is being written the slave raises a busy flag and ignores the bus. A supply-low input blocks the commit of a write.

Top module: `twim_slave`

## Requirements
- R1: A START (data falling while clock is high) followed by a control byte whose upper four bits are 1010 is acknowledged. The slave holds data low for the whole ninth clock pulse. The data enable is only ever asserted while the clock is low.
- R2: A control byte with any other device code is not acknowledged. All later bytes are ignored without acknowledge until the next START.
- R3: In a write, the second byte is the word address. Its low four bits load the pointer and its high four bits have no effect.
- R4: A STOP after a fully received and acknowledged data byte writes that byte at the pointer. busy_o then rises on the next clock and stays high for exactly WR_CYCLES clocks.
- R5: While busy_o is high the slave acknowledges nothing and ignores START, STOP and bits.
- R6: A byte write leaves the pointer unchanged, so the next current-address read returns the byte just written.
- R7: A STOP before the first data byte is complete (after the address, or mid-byte) writes nothing and leaves busy_o low.
- R8: When more than eight data bits arrive, the held byte is dropped and loading restarts. A STOP after a later complete byte writes only that last byte.
- R9: A STOP after one or more complete data bytes and part of a further byte writes nothing.
- R10: With supply_low_i high when the STOP is seen, the array is left unchanged and busy_o stays low.
- R11: Read bit 0 of the control byte is 1. The slave sends the byte at the pointer MSB first and then advances the pointer modulo 16. It continues while the master acknowledges, and releases data after a master no-acknowledge.
- R12: The three bits between the device code and the read/write bit are don't-care. Any value is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | High pulls the data line low |
| supply_low_i | input | 1 | Low-supply inhibit, blocks the write commit |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
The hardest cases to reach are the abort paths around extra data bits. A STOP is itself a clock rise with data low, so the slave must not mistake it for the first bit of a new byte. It must still abort when a real partial byte precedes the STOP. The stimulus drives the bus one bit at a time. It sends a full byte followed by only a few bits before the STOP, and it also sends two complete data bytes before the STOP. The memory is then read back through the bus and compared with the behavioural model.

// File: rtl/twim_pkg.sv
package twim_pkg;
  localparam logic [3:0] TWIM_DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_RD,
    ST_MACK,
    ST_IGNORE
  } twim_state_e;
endpackage

// File: rtl/twim_sync.sv
module twim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_lvl  = scl_p[STAGES-1];
  assign sda_lvl  = sda_p[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_c  = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_c   = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twim_regfile.sv
module twim_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       word[g] <= '0;
      else if (we && addr == AW'(g))    word[g] <= wdata;
    end
  end

  assign rdata = word[addr];
endmodule

// File: rtl/twim_wtimer.sv
module twim_wtimer #(
  parameter int WR_CYCLES = 1000,
  localparam int CW       = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start_i)        remain <= CW'(WR_CYCLES);
    else if (remain != '0)   remain <= remain - CW'(1);
  end

  assign busy_o = (remain != '0);

  p_busy_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
endmodule

// File: rtl/twim_ctrl.sv
module twim_ctrl
  import twim_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              busy_i,
  input  logic              inhibit_i,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [AW-1:0]     ptr,
  output logic              we,
  output logic [DATA_W-1:0] wdata
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  twim_state_e       state;
  twim_state_e       ret_state;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              dvalid;
  logic              mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      shreg     <= '0;
      txreg     <= '0;
      bitcnt    <= '0;
      dvalid    <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      we        <= 1'b0;
      wdata     <= '0;
    end else begin
      we <= 1'b0;
      if (busy_i) begin
        state <= ST_IDLE;
      end else if (start_c) begin
        state  <= ST_CTRL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        dvalid <= 1'b0;
      end else if (stop_c) begin
        if (state == ST_DATA && dvalid && !inhibit_i) we <= 1'b1;
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        dvalid <= 1'b0;
      end else begin
        case (state)
          ST_CTRL, ST_ADDR, ST_DATA: begin
            if (scl_rise && bitcnt != CNT_W'(DATA_W)) begin
              shreg  <= {shreg[DATA_W-2:0], sda_lvl};
              bitcnt <= bitcnt + CNT_W'(1);
            end else if (scl_fall) begin
              // a completed bit clock of a new byte drops the held byte
              if (state == ST_DATA && bitcnt == CNT_W'(1)) dvalid <= 1'b0;
              if (bitcnt == CNT_W'(DATA_W)) begin
                bitcnt <= '0;
                if (state == ST_CTRL) begin
                  if (shreg[DATA_W-1 -: 4] == TWIM_DEV_CODE) begin
                    sda_oe    <= 1'b1;
                    state     <= ST_ACK;
                    ret_state <= shreg[0] ? ST_RD : ST_ADDR;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end else if (state == ST_ADDR) begin
                  ptr       <= shreg[AW-1:0];
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= ST_DATA;
                end else begin
                  wdata     <= shreg;
                  dvalid    <= 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= ST_DATA;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= ret_state;
              if (ret_state == ST_RD) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
                ptr    <= ptr + AW'(1);
                bitcnt <= '0;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == CNT_W'(DATA_W - 1)) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~txreg[DATA_W-2];
                txreg  <= {txreg[DATA_W-2:0], 1'b0};
                bitcnt <= bitcnt + CNT_W'(1);
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
                ptr    <= ptr + AW'(1);
                bitcnt <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_drive_low_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
  p_silent_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !sda_oe);
  p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$past(inhibit_i));
endmodule

// File: rtl/twim_slave.sv
module twim_slave #(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 8,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic supply_low_i,
  output logic busy_o
);
  localparam int AW = $clog2(DEPTH);

  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic              we;
  logic [AW-1:0]     ptr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  twim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  twim_ctrl #(.AW(AW), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
    .stop_c(stop_c), .busy_i(busy_o), .inhibit_i(supply_low_i),
    .rd_data(rdata), .sda_oe(sda_oe_o), .ptr(ptr), .we(we), .wdata(wdata)
  );

  twim_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(ptr), .wdata(wdata),
    .rdata(rdata)
  );

  twim_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(we), .busy_o(busy_o)
  );

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(ptr));
endmodule

// File: tb/tb_twim_slave.sv
module tb_twim_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WR = 400;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic supply_low = 1'b0;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int busy_run = 0;
  int busy_last = 0;
  logic [7:0] model_mem [16];
  int model_ptr = 0;

  always #2 clk = ~clk;

  twim_slave #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .supply_low_i(supply_low), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model comparison of the busy window
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        busy_run++;
        chk("R5 no drive while busy", int'(sda_oe), 0);
      end else if (busy_run != 0) begin
        busy_last = busy_run;
        busy_run  = 0;
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H);
    sda_m = 1'b0; waitc(H); scl_m = 1'b0; waitc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(H); scl_m = 1'b1; waitc(H);
    sda_m = 1'b1; waitc(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; waitc(H); scl_m = 1'b1; waitc(H); scl_m = 1'b0; waitc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H / 2);
    acked = ~sda_line; waitc(H / 2); scl_m = 1'b0; waitc(H);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scl_m = 1'b1; waitc(H / 2); v = {v[6:0], sda_line};
      waitc(H / 2); scl_m = 1'b0; waitc(H);
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) waitc(1);
    waitc(4);
  endtask

  task automatic write_byte(input logic [7:0] ctl, input logic [7:0] a,
                            input logic [7:0] d, input string req);
    logic ak;
    bus_start();
    send_byte(ctl, ak); chk({req, " ctrl ack"}, int'(ak), 1);
    send_byte(a, ak);   chk({req, " addr ack"}, int'(ak), 1);
    send_byte(d, ak);   chk({req, " data ack"}, int'(ak), 1);
    bus_stop();
    model_ptr = int'(a[3:0]);
  endtask

  task automatic rand_read(input logic [3:0] a, input int n, input string req);
    logic ak;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA0, ak); chk({req, " ctrl ack"}, int'(ak), 1);
    send_byte({4'h0, a}, ak); chk({req, " addr ack"}, int'(ak), 1);
    model_ptr = int'(a);
    bus_start();
    send_byte(8'hA1, ak); chk({req, " rd ctrl ack"}, int'(ak), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk({req, " read data"}, int'(v), int'(model_mem[model_ptr]));
      model_ptr = (model_ptr + 1) % 16;
    end
    chk({req, " released after nack"}, int'(sda_oe), 0);
    bus_stop();
    waitc(H);
    chk({req, " no busy after read"}, int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(180000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ak;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) model_mem[i] = 8'h00;
    waitc(5);
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R4 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    waitc(5);

    // R1 R4: basic byte write, busy length
    write_byte(8'hA0, 8'h03, 8'hA5, "R1");
    model_mem[3] = 8'hA5;
    waitc(10);
    chk("R4 busy after write", int'(busy), 1);
    // R5: control byte during busy is not acknowledged
    bus_start();
    send_byte(8'hA1, ak); chk("R5 no ack while busy", int'(ak), 0);
    bus_stop();
    wait_idle();
    chk("R4 busy length", busy_last, WR);

    // R6: current address read returns the byte just written
    bus_start();
    send_byte(8'hA1, ak); chk("R6 ctrl ack", int'(ak), 1);
    recv_byte(1'b0, v);
    chk("R6 current read", int'(v), 8'hA5);
    chk("R11 released after nack", int'(sda_oe), 0);
    bus_stop();
    model_ptr = 4;

    // R3: upper address bits ignored
    write_byte(8'hA0, 8'hF7, 8'h3C, "R3");
    model_mem[7] = 8'h3C;
    wait_idle();
    rand_read(4'h7, 1, "R3");

    // R12: don't-care bits in control byte
    write_byte(8'hAE, 8'h05, 8'h11, "R12");
    model_mem[5] = 8'h11;
    wait_idle();
    rand_read(4'h5, 1, "R12");

    // R2: wrong device code
    bus_start();
    send_byte(8'hB0, ak); chk("R2 no ack bad code", int'(ak), 0);
    send_byte(8'hA0, ak); chk("R2 later byte ignored", int'(ak), 0);
    bus_stop();
    waitc(20);
    chk("R2 no busy", int'(busy), 0);

    // R7: stop after address only
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h03, ak);
    bus_stop();
    waitc(20);
    chk("R7 no busy after addr stop", int'(busy), 0);
    // R7: stop mid data byte
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h05, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    waitc(20);
    chk("R7 no busy mid byte", int'(busy), 0);
    rand_read(4'h3, 1, "R7");
    rand_read(4'h5, 1, "R7");

    // R8: two full data bytes, the last one is written
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h09, ak);
    send_byte(8'h12, ak); chk("R8 first data ack", int'(ak), 1);
    send_byte(8'h34, ak); chk("R8 second data ack", int'(ak), 1);
    bus_stop();
    model_mem[9] = 8'h34;
    waitc(10);
    chk("R8 busy", int'(busy), 1);
    wait_idle();
    rand_read(4'h9, 1, "R8");

    // R9: full byte then partial byte aborts
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h0A, ak);
    send_byte(8'h55, ak); chk("R9 data ack", int'(ak), 1);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop();
    waitc(20);
    chk("R9 no busy", int'(busy), 0);
    rand_read(4'hA, 1, "R9");

    // R10: supply low blocks write
    supply_low = 1'b1;
    write_byte(8'hA0, 8'h03, 8'h77, "R10");
    waitc(20);
    chk("R10 no busy", int'(busy), 0);
    supply_low = 1'b0;
    rand_read(4'h3, 1, "R10");

    // R11: sequential read across wrap
    write_byte(8'hA0, 8'h0F, 8'hC3, "R11");
    model_mem[15] = 8'hC3;
    wait_idle();
    rand_read(4'hF, 3, "R11");

    waitc(20);
    finish_run();
  end
endmodule